// File: doc/BRIEF.md
# Configuration Request Packet Builder

This block turns one configuration-space access into a three-dword request header and sends it to the link layer as 64-bit beats. An access names a bus, a device/function, a byte offset, a size of 1, 2 or 4 bytes, a direction and write data. Each beat carries two 32-bit words, `tx_w0` first and `tx_w1` second, plus start and end flags. The stream uses valid/ready: a beat moves on a cycle where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the beat holds steady. The sink may hold `tx_ready` low for any number of cycles.

The block keeps its own copy of the root bus number. The header type depends on it, and so does the requester ID. The copy is updated by watching successful writes to the primary-bus register of the root port. Some accesses must never reach the link. The block refuses these at once with a status pulse and sends no packet. For an access that does go out, the block passes the tag and direction to a completion tracker. It then stays busy until the tracker reports done. Only one request is in flight at a time.

Top module: `cfgb_req_builder`

## Requirements
- R1: Header dword 0 holds the format/type byte in bits 31:24 and a length of 1 in its low bits, so it reads 0x04000001 / 0x44000001 for read / write when the target bus equals the stored root bus, and 0x05000001 / 0x45000001 otherwise.
- R2: Header dword 1 is {root bus, 8'h00, tag, byte enables in bits 7:0}. The tag is 0x1D for reads and 0x10 for writes.
- R3: Header dword 2 is {bus in 31:24, devfn in 23:16, offset in 15:0 with bits 1:0 forced to zero}.
- R4: `req_size` 0 selects 1 byte, giving enables 4'b0001 << offset[1:0]. Size 1 selects 2 bytes, giving 4'b0011 << offset[1:0] with bits shifted past bit 3 dropped. Sizes 2 and 3 select 4 bytes, giving 4'hF with data unshifted. For 1- and 2-byte writes, the data is masked to its size and shifted left by 8 × offset[1:0].
- R5: A read, or a write whose offset[2:0] is not 0, goes out as two beats. The first is {DW0, DW1} with only start set. The second is {DW2, data} with only end set, where data is 0 for a read.
- R6: A write whose offset[2:0] is 0 goes out as three beats: {DW0, DW1} with start, then {DW2, 0} with no flag, then {data, 0} with end.
- R7: An access on the root bus with devfn 0 and offset exactly 0x10 is refused with status 2'b01. No beat is sent.
- R8: An access is refused with status 2'b10 and no beat in two cases: on the root bus with device number devfn[7:3] not 0, or on another bus while `link_up` is low. A refused read reports `rsp_rdata` = 0xFFFFFFFF; a refused write reports 0.
- R9: On `cpl_done` with `cpl_ok` high, a write to the root bus whose dword-aligned offset is 0x18 sets the root bus number to bits 7:0 of the shifted write data. Nothing else changes the root bus number. Its value after reset is the parameter `ROOT_RST` (0 by default).
- R10: `req_ready` is low from the accept cycle until the cycle after `cpl_done`. One cycle after the last beat moves, `trk_valid` pulses for one cycle with `trk_tag` and `trk_write`.
- R11: While `tx_valid` is high and `tx_ready` is low, the beat words and flags hold their values and `tx_valid` stays high.
- R12: After reset, `req_ready` is high, `tx_valid`, `rsp_valid` and `trk_valid` are low, and `root_bus` is `ROOT_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Block can accept an access |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_offset | input | OFS_W | Byte offset in configuration space |
| req_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2/3: 4 bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, right-aligned |
| link_up | input | 1 | Link trained and usable |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Sink takes the beat |
| tx_w0 | output | 32 | First word of the beat |
| tx_w1 | output | 32 | Second word of the beat |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |
| rsp_valid | output | 1 | One-cycle pulse on a refused access |
| rsp_status | output | 2 | 01 bad register, 10 no device |
| rsp_rdata | output | 32 | Read value for a refused access |
| trk_valid | output | 1 | One-cycle pulse after the packet is sent |
| trk_tag | output | 8 | Tag of the sent request |
| trk_write | output | 1 | Sent request was a write |
| cpl_done | input | 1 | Tracker: completion arrived |
| cpl_ok | input | 1 | Tracker: completion status was success |
| root_bus | output | 8 | Stored root bus number |

## Verification
The hardest case to reach from the ports is a change of the root bus number, followed by accesses that depend on it. One such case is a byte write at offset 0x19, whose shifted data gives a new root bus of zero. Another is a write at 0x18 that completes with failure. The vector table is walked in order, so earlier entries leave the root bus at a chosen value. Later entries then check that the header type, the requester ID, the refusal rules and the link dependence all follow the new value. Each vector also holds `tx_ready` low for a cycle on every beat, so the hold rule is exercised on every beat position of both the two-beat and the three-beat layouts.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [1:0] {
    CST_OK     = 2'b00,
    CST_BADREG = 2'b01,
    CST_NODEV  = 2'b10
  } cfg_status_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_CHECK = 2'd1,
    CS_SEND  = 2'd2,
    CS_WAIT  = 2'd3
  } ctrl_state_e;

  typedef struct packed {
    logic [31:0] w0;
    logic [31:0] w1;
    logic        sop;
    logic        eop;
  } beat_t;

  localparam logic [7:0]  FT_RD_T0   = 8'h04;
  localparam logic [7:0]  FT_WR_T0   = 8'h44;
  localparam logic [7:0]  FT_RD_T1   = 8'h05;
  localparam logic [7:0]  FT_WR_T1   = 8'h45;
  localparam logic [7:0]  TAG_RD     = 8'h1D;
  localparam logic [7:0]  TAG_WR     = 8'h10;
  localparam logic [15:0] OFS_HIDDEN = 16'h0010;
  localparam logic [15:0] OFS_PRIBUS = 16'h0018;
  localparam int          BEATS_MAX  = 3;

endpackage

// File: rtl/cfgb_filter.sv
module cfgb_filter
  import cfgb_pkg::*;
#(
  parameter int OFS_W = 12
) (
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFS_W-1:0] offset,
  input  logic [7:0]       root,
  input  logic             link_up,
  output cfg_status_e      status
);
  logic [15:0] ofs16;
  logic        on_root;

  assign ofs16   = 16'(offset);
  assign on_root = (bus == root);

  always_comb begin
    if (on_root && devfn == 8'h00 && ofs16 == OFS_HIDDEN)
      status = CST_BADREG;
    else if (on_root && devfn[7:3] != 5'd0)
      status = CST_NODEV;
    else if (!on_root && !link_up)
      status = CST_NODEV;
    else
      status = CST_OK;
  end
endmodule

// File: rtl/cfgb_hdr.sv
module cfgb_hdr
  import cfgb_pkg::*;
#(
  parameter int OFS_W = 12,
  parameter int IDX_W = 2
) (
  input  logic [7:0]       bus,
  input  logic [7:0]       devfn,
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size,
  input  logic             wr,
  input  logic [31:0]      wdata,
  input  logic [7:0]       root,
  input  logic [IDX_W-1:0] beat_idx,
  output beat_t            beat,
  output logic             last,
  output logic [31:0]      data_al,
  output logic [15:0]      dw_ofs
);
  localparam int LANES = 4;

  logic [1:0]       sh;
  logic             full;
  logic [2:0]       nbytes;
  logic [31:0]      shifted;
  logic [LANES-1:0] be;
  logic [31:0]      dw0, dw1, dw2;
  logic             three;

  assign sh      = offset[1:0];
  assign full    = size[1];
  assign nbytes  = (size == 2'd0) ? 3'd1 : 3'd2;
  assign shifted = wdata << {sh, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic in_win;
    assign in_win = (3'(i) >= {1'b0, sh}) && (3'(i) < ({1'b0, sh} + nbytes));
    assign be[i]  = full | in_win;
    assign data_al[8*i +: 8] = full ? wdata[8*i +: 8] :
                               (in_win ? shifted[8*i +: 8] : 8'h00);
  end

  assign dw_ofs = 16'(offset) & 16'hFFFC;
  assign dw0 = {(bus == root) ? (wr ? FT_WR_T0 : FT_RD_T0)
                              : (wr ? FT_WR_T1 : FT_RD_T1), 24'h000001};
  assign dw1 = {root, 8'h00, wr ? TAG_WR : TAG_RD, 4'h0, be};
  assign dw2 = {bus, devfn, dw_ofs};
  assign three = wr && (offset[2:0] == 3'd0);

  always_comb begin
    beat = '0;
    last = 1'b0;
    case (beat_idx)
      IDX_W'(0): begin
        beat.w0  = dw0;
        beat.w1  = dw1;
        beat.sop = 1'b1;
      end
      IDX_W'(1): begin
        beat.w0 = dw2;
        if (three) begin
          beat.w1 = 32'h0;
        end else begin
          beat.w1  = wr ? data_al : 32'h0;
          beat.eop = 1'b1;
          last     = 1'b1;
        end
      end
      default: begin
        beat.w0  = data_al;
        beat.eop = 1'b1;
        last     = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
  import cfgb_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  cfg_status_e      status,
  input  logic             tx_ready,
  input  logic             last,
  input  logic             cpl_done,
  output logic             req_ready,
  output logic             latch_en,
  output logic             refuse_now,
  output logic             tx_valid,
  output logic [IDX_W-1:0] beat_idx,
  output logic             rsp_valid,
  output logic             trk_valid,
  output logic             cpl_take
);
  ctrl_state_e state;

  assign req_ready  = (state == CS_IDLE);
  assign latch_en   = req_ready && req_valid;
  assign refuse_now = (state == CS_CHECK) && (status != CST_OK);
  assign tx_valid   = (state == CS_SEND);
  assign cpl_take   = (state == CS_WAIT) && cpl_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= CS_IDLE;
      beat_idx  <= '0;
      rsp_valid <= 1'b0;
      trk_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      trk_valid <= 1'b0;
      case (state)
        CS_IDLE:  if (req_valid) state <= CS_CHECK;
        CS_CHECK: begin
          beat_idx <= '0;
          if (status != CST_OK) begin
            rsp_valid <= 1'b1;
            state     <= CS_IDLE;
          end else begin
            state <= CS_SEND;
          end
        end
        CS_SEND: if (tx_ready) begin
          if (last) begin
            trk_valid <= 1'b1;
            state     <= CS_WAIT;
          end else begin
            beat_idx <= beat_idx + 1'b1;
          end
        end
        default: if (cpl_done) state <= CS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgb_req_builder.sv
module cfgb_req_builder
  import cfgb_pkg::*;
#(
  parameter int         OFS_W    = 12,
  parameter logic [7:0] ROOT_RST = 8'h00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [7:0]       req_bus,
  input  logic [7:0]       req_devfn,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [31:0]      req_wdata,
  input  logic             link_up,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [31:0]      tx_w0,
  output logic [31:0]      tx_w1,
  output logic             tx_sop,
  output logic             tx_eop,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic [31:0]      rsp_rdata,
  output logic             trk_valid,
  output logic [7:0]       trk_tag,
  output logic             trk_write,
  input  logic             cpl_done,
  input  logic             cpl_ok,
  output logic [7:0]       root_bus
);
  localparam int IDX_W = $clog2(BEATS_MAX);

  logic [7:0]       q_bus, q_devfn;
  logic [OFS_W-1:0] q_ofs;
  logic [1:0]       q_size;
  logic             q_wr;
  logic [31:0]      q_wdata;
  logic [7:0]       root_q;

  cfg_status_e      status;
  beat_t            beat;
  logic             last, latch_en, refuse_now, cpl_take;
  logic [IDX_W-1:0] beat_idx;
  logic [31:0]      data_al;
  logic [15:0]      dw_ofs;

  cfgb_filter #(.OFS_W(OFS_W)) u_filter (
    .bus(q_bus), .devfn(q_devfn), .offset(q_ofs), .root(root_q),
    .link_up(link_up), .status(status)
  );

  cfgb_hdr #(.OFS_W(OFS_W), .IDX_W(IDX_W)) u_hdr (
    .bus(q_bus), .devfn(q_devfn), .offset(q_ofs), .size(q_size),
    .wr(q_wr), .wdata(q_wdata), .root(root_q), .beat_idx(beat_idx),
    .beat(beat), .last(last), .data_al(data_al), .dw_ofs(dw_ofs)
  );

  cfgb_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .status(status),
    .tx_ready(tx_ready), .last(last), .cpl_done(cpl_done),
    .req_ready(req_ready), .latch_en(latch_en), .refuse_now(refuse_now),
    .tx_valid(tx_valid), .beat_idx(beat_idx), .rsp_valid(rsp_valid),
    .trk_valid(trk_valid), .cpl_take(cpl_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_bus      <= '0;
      q_devfn    <= '0;
      q_ofs      <= '0;
      q_size     <= '0;
      q_wr       <= 1'b0;
      q_wdata    <= '0;
      root_q     <= ROOT_RST;
      rsp_status <= '0;
      rsp_rdata  <= '0;
    end else begin
      if (latch_en) begin
        q_bus   <= req_bus;
        q_devfn <= req_devfn;
        q_ofs   <= req_offset;
        q_size  <= req_size;
        q_wr    <= req_write;
        q_wdata <= req_wdata;
      end
      if (refuse_now) begin
        rsp_status <= status;
        rsp_rdata  <= q_wr ? 32'h0 : 32'hFFFF_FFFF;
      end
      if (cpl_take && cpl_ok && q_wr && (q_bus == root_q) && (dw_ofs == OFS_PRIBUS))
        root_q <= data_al[7:0];
    end
  end

  assign tx_w0     = beat.w0;
  assign tx_w1     = beat.w1;
  assign tx_sop    = beat.sop;
  assign tx_eop    = beat.eop;
  assign trk_tag   = q_wr ? TAG_WR : TAG_RD;
  assign trk_write = q_wr;
  assign root_bus  = root_q;
endmodule

// File: rtl/cfgb_req_builder_chk.sv
module cfgb_req_builder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_w0,
  input logic [31:0] tx_w1,
  input logic        tx_sop,
  input logic        tx_eop,
  input logic        rsp_valid,
  input logic [1:0]  rsp_status,
  input logic        trk_valid,
  input logic        cpl_done,
  input logic [7:0]  root_bus
);
  assert_hold_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_w0) && $stable(tx_w1)
                              && $stable(tx_sop) && $stable(tx_eop));

  assert_busy_tx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready);

  assert_trk_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    trk_valid |=> !trk_valid);

  assert_root_only_on_cpl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_done |=> $stable(root_bus));

  assert_refuse_no_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !tx_valid && (rsp_status != 2'b00) && (rsp_status != 2'b11));

  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(tx_sop && tx_eop));

  assert_dw0_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_sop |-> (tx_w0[23:0] == 24'h000001)
                           && (tx_w0[31:24] inside {8'h04, 8'h05, 8'h44, 8'h45}));
endmodule

bind cfgb_req_builder cfgb_req_builder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_w0(tx_w0), .tx_w1(tx_w1), .tx_sop(tx_sop),
  .tx_eop(tx_eop), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
  .trk_valid(trk_valid), .cpl_done(cpl_done), .root_bus(root_bus)
);

// File: tb/cfgb_req_builder_tb.sv
module cfgb_req_builder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NV         = 16;

  typedef struct packed {
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [11:0] ofs;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
    logic        link;
    logic        cok;
    logic [1:0]  nb;
    logic [1:0]  st;
    logic [31:0] rd;
    logic [31:0] b0w0, b0w1, b1w0, b1w1, b2w0;
    logic [7:0]  root;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h00,8'h00,12'h004,2'd2,1'b0,32'h0,1'b1,1'b1,2'd2,2'd0,32'h0,
      32'h04000001,32'h00001D0F,32'h00000004,32'h0,32'h0,8'h00},
    '{8'h00,8'h00,12'h00C,2'd2,1'b1,32'h12345678,1'b1,1'b1,2'd2,2'd0,32'h0,
      32'h44000001,32'h0000100F,32'h0000000C,32'h12345678,32'h0,8'h00},
    '{8'h02,8'h08,12'h008,2'd0,1'b1,32'h000000AB,1'b1,1'b1,2'd3,2'd0,32'h0,
      32'h45000001,32'h00001001,32'h02080008,32'h0,32'h000000AB,8'h00},
    '{8'h01,8'h10,12'h102,2'd1,1'b0,32'h0,1'b1,1'b1,2'd2,2'd0,32'h0,
      32'h05000001,32'h00001D0C,32'h01100100,32'h0,32'h0,8'h00},
    '{8'h01,8'h00,12'h013,2'd0,1'b1,32'h0000005A,1'b1,1'b1,2'd2,2'd0,32'h0,
      32'h45000001,32'h00001008,32'h01000010,32'h5A000000,32'h0,8'h00},
    '{8'h00,8'h00,12'h010,2'd2,1'b1,32'hDEADBEEF,1'b1,1'b1,2'd0,2'd1,32'h0,
      32'h0,32'h0,32'h0,32'h0,32'h0,8'h00},
    '{8'h00,8'h08,12'h000,2'd2,1'b0,32'h0,1'b1,1'b1,2'd0,2'd2,32'hFFFFFFFF,
      32'h0,32'h0,32'h0,32'h0,32'h0,8'h00},
    '{8'h03,8'h00,12'h000,2'd2,1'b0,32'h0,1'b0,1'b1,2'd0,2'd2,32'hFFFFFFFF,
      32'h0,32'h0,32'h0,32'h0,32'h0,8'h00},
    '{8'h00,8'h01,12'h020,2'd1,1'b1,32'h00001234,1'b0,1'b1,2'd3,2'd0,32'h0,
      32'h44000001,32'h00001003,32'h00010020,32'h0,32'h00001234,8'h00},
    '{8'h00,8'h00,12'h018,2'd2,1'b1,32'h00AA0305,1'b1,1'b1,2'd3,2'd0,32'h0,
      32'h44000001,32'h0000100F,32'h00000018,32'h0,32'h00AA0305,8'h05},
    '{8'h05,8'h00,12'h000,2'd2,1'b0,32'h0,1'b0,1'b1,2'd2,2'd0,32'h0,
      32'h04000001,32'h05001D0F,32'h05000000,32'h0,32'h0,8'h05},
    '{8'h00,8'h00,12'h000,2'd2,1'b0,32'h0,1'b0,1'b1,2'd0,2'd2,32'hFFFFFFFF,
      32'h0,32'h0,32'h0,32'h0,32'h0,8'h05},
    '{8'h05,8'h00,12'h018,2'd2,1'b1,32'h00000077,1'b1,1'b0,2'd3,2'd0,32'h0,
      32'h44000001,32'h0500100F,32'h05000018,32'h0,32'h00000077,8'h05},
    '{8'h05,8'h00,12'h010,2'd2,1'b0,32'h0,1'b1,1'b1,2'd0,2'd1,32'hFFFFFFFF,
      32'h0,32'h0,32'h0,32'h0,32'h0,8'h05},
    '{8'h05,8'h00,12'h019,2'd0,1'b1,32'h00000033,1'b1,1'b1,2'd2,2'd0,32'h0,
      32'h44000001,32'h05001002,32'h05000018,32'h00003300,32'h0,8'h00},
    '{8'h00,8'h00,12'h000,2'd2,1'b0,32'h0,1'b0,1'b1,2'd2,2'd0,32'h0,
      32'h04000001,32'h00001D0F,32'h00000000,32'h0,32'h0,8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [7:0]  req_bus = '0, req_devfn = '0;
  logic [11:0] req_offset = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        link_up = 1'b0;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_w0, tx_w1;
  logic        tx_sop, tx_eop;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_rdata;
  logic        trk_valid;
  logic [7:0]  trk_tag;
  logic        trk_write;
  logic        cpl_done = 1'b0, cpl_ok = 1'b0;
  logic [7:0]  root_bus;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfgb_req_builder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .link_up(link_up), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_w0(tx_w0), .tx_w1(tx_w1), .tx_sop(tx_sop), .tx_eop(tx_eop),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
    .trk_valid(trk_valid), .trk_tag(trk_tag), .trk_write(trk_write),
    .cpl_done(cpl_done), .cpl_ok(cpl_ok), .root_bus(root_bus)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=0", WD_CYCLES);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    logic [31:0] ew0, ew1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    check("R12 req_ready", 32'(req_ready), 32'd1);
    check("R12 tx_valid", 32'(tx_valid), 32'd0);
    check("R12 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R12 trk_valid", 32'(trk_valid), 32'd0);
    check("R12 root_bus", 32'(root_bus), 32'd0);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      link_up    = v.link;
      req_bus    = v.bus;
      req_devfn  = v.devfn;
      req_offset = v.ofs;
      req_size   = v.size;
      req_write  = v.wr;
      req_wdata  = v.wdata;
      req_valid  = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 busy after accept", 32'(req_ready), 32'd0);
      @(negedge clk);
      if (v.nb == 2'd0) begin
        // R7 / R8: refusal, no packet
        check("R7 R8 rsp_valid", 32'(rsp_valid), 32'd1);
        check("R7 R8 rsp_status", 32'(rsp_status), 32'(v.st));
        check("R8 rsp_rdata", rsp_rdata, v.rd);
        check("R7 no beat", 32'(tx_valid), 32'd0);
        @(negedge clk);
        check("R7 no beat after", 32'(tx_valid), 32'd0);
        check("R9 root kept", 32'(root_bus), 32'(v.root));
      end else begin
        for (int i = 0; i < int'(v.nb); i++) begin
          ew0 = (i == 0) ? v.b0w0 : (i == 1) ? v.b1w0 : v.b2w0;
          ew1 = (i == 0) ? v.b0w1 : (i == 1) ? v.b1w1 : 32'h0;
          // R1 R2 R3 R4 R5 R6: beat contents
          check("R5 R6 tx_valid", 32'(tx_valid), 32'd1);
          check("R1 R2 R3 R4 R5 R6 w0", tx_w0, ew0);
          check("R1 R2 R3 R4 R5 R6 w1", tx_w1, ew1);
          check("R5 R6 sop", 32'(tx_sop), 32'(i == 0));
          check("R5 R6 eop", 32'(tx_eop), 32'(i == int'(v.nb) - 1));
          @(negedge clk);
          // R11: held under back-pressure
          check("R11 hold valid", 32'(tx_valid), 32'd1);
          check("R11 hold w0", tx_w0, ew0);
          check("R11 hold w1", tx_w1, ew1);
          tx_ready = 1'b1;
          @(negedge clk);
          tx_ready = 1'b0;
        end
        check("R5 R6 no extra beat", 32'(tx_valid), 32'd0);
        check("R10 trk_valid", 32'(trk_valid), 32'd1);
        check("R10 trk_tag", 32'(trk_tag), v.wr ? 32'h10 : 32'h1D);
        check("R10 trk_write", 32'(trk_write), 32'(v.wr));
        check("R10 busy while waiting", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R10 trk pulse ends", 32'(trk_valid), 32'd0);
        check("R10 still busy", 32'(req_ready), 32'd0);
        cpl_ok   = v.cok;
        cpl_done = 1'b1;
        @(negedge clk);
        cpl_done = 1'b0;
        cpl_ok   = 1'b0;
        check("R9 root_bus", 32'(root_bus), 32'(v.root));
        check("R10 ready after done", 32'(req_ready), 32'd1);
      end
    end

    // R12: reset in the middle of a packet returns to idle state and root value
    req_bus = 8'h00; req_devfn = 8'h00; req_offset = 12'h018; req_size = 2'd2;
    req_write = 1'b1; req_wdata = 32'h00000009; link_up = 1'b1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R6 mid-reset beat up", 32'(tx_valid), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R12 tx_valid after reset", 32'(tx_valid), 32'd0);
    check("R12 req_ready after reset", 32'(req_ready), 32'd1);
    check("R12 root after reset", 32'(root_bus), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule